// File: doc/BRIEF.md
# Dual-Role Bus Mastership and Init Glue

This block sits between a CPU card and a shared DMA/interrupt bus and lets the same card run either as the bus arbiter or as a pass-through auxiliary. A static role strap picks the mode. In arbiter mode the block grants the bus to one requester at a time, drives bus init, and accepts the bus interrupt request lines. In auxiliary mode the internal arbitration is switched off. The block then takes its grant from the external grant-in line, answers with select-acknowledge, forwards grants and interrupt acknowledges it does not need, and treats a received bus init as a local reset.

Both roles raise the bus request line while the local CPU wants the bus and does not yet hold it. All sequential state sits behind a reset synchroniser. The bus init output, the grant state and the interrupt front end are built as separate units under the top.

Top module: `role_bus_glue`

## Requirements
- R1: In either role, `bus_req_o` equals `loc_req_i` AND NOT `loc_grant_o`.
- R2: In arbiter mode, when no grant is held and `sack_in_i` is low at a clock edge, the block grants exactly one requester, with the grant visible after that edge. The winner is the lowest index in the vector {`ext_req_i`, `loc_req_i`}: the local CPU is index 0 and `ext_req_i[k]` is index k+1. While `sack_in_i` is high, no new grant is issued.
- R3: In arbiter mode, a grant is held unchanged until it is released. An external holder is released when `sack_in_i` is high at an edge. The local holder is released when `loc_req_i` is low at an edge. The grant output is zero after the releasing edge.
- R4: In auxiliary mode, `ext_grant_o` stays zero. `loc_grant_o` and `sack_o` rise at the edge where `grant_in_i` and `loc_req_i` are both high. They stay high until the edge where `loc_req_i` is low.
- R5: `grant_out_o` equals `grant_in_i` AND NOT `loc_req_i` in the same cycle in auxiliary mode, and is zero in arbiter mode.
- R6: `sack_o` is never high in arbiter mode.
- R7: In arbiter mode, `binit_o` is high while `dcok_i` is low. It is also high for INIT_CYC cycles after an edge at which `binit_wr_i` is high. In auxiliary mode, `binit_o` is never high.
- R8: `loc_rst_o` is high when `dcok_i` is low, or when the role is auxiliary and `binit_in_i` is high. While it is high, all grant and acknowledge state is cleared at the next edge. A received `binit_in_i` has no effect in arbiter mode.
- R9: In arbiter mode, `irq_pend_o` is the OR of `irq_i`, and `irq_lvl_o` is the index of the highest set bit. Bit 3 is the line with level 7 and bit 0 is level 4, and the index is 0 when no bit is set. In auxiliary mode, both outputs are zero whatever `irq_i` holds.
- R10: In arbiter mode, `iack_out_o` equals `cpu_iack_i` AND a pending interrupt, and `iack_in_i` is ignored. In auxiliary mode, `iack_out_o` equals `iack_in_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| role_arb_i | input | 1 | Role strap: 1 arbiter, 0 auxiliary |
| loc_req_i | input | 1 | Local CPU wants the bus |
| dcok_i | input | 1 | DC power good (low = failing) |
| binit_wr_i | input | 1 | Write strobe of the bus initialize register |
| grant_in_i | input | 1 | External grant-in pin |
| sack_in_i | input | 1 | Select-acknowledge seen on the bus |
| binit_in_i | input | 1 | Bus init received from the bus |
| ext_req_i | input | N_EXT | DMA requests of other bus masters |
| irq_i | input | 4 | Bus interrupt request lines, levels 4..7 |
| cpu_iack_i | input | 1 | Local CPU services a bus interrupt |
| iack_in_i | input | 1 | Interrupt acknowledge in |
| bus_req_o | output | 1 | Bus DMA request |
| loc_grant_o | output | 1 | Grant to local CPU |
| ext_grant_o | output | N_EXT | Grants to other masters (arbiter mode) |
| sack_o | output | 1 | Select-acknowledge driven to bus |
| binit_o | output | 1 | Bus init driven to bus |
| grant_out_o | output | 1 | Grant passed downstream |
| loc_rst_o | output | 1 | Local reset |
| irq_pend_o | output | 1 | Bus interrupt accepted and pending |
| irq_lvl_o | output | 2 | Highest pending line index |
| iack_out_o | output | 1 | Interrupt acknowledge out |

## Verification
The hardest situations to reach are a grant that must persist across several cycles while its holder still has not acknowledged, and a new request that arrives while the bus is still busy with select-acknowledge. The bench sweeps every one of the 15 non-empty request patterns twice. First it holds `sack_in_i` high to prove that no grant is issued. Then it lowers `sack_in_i` and holds the winner for extra cycles before releasing it with the release rule that matches the holder. The auxiliary path is swept over every grant-in and request combination. A received init is then asserted while a grant is held, which shows that the local reset wins over an active request.

// File: rtl/rbg_pkg.sv
package rbg_pkg;
  localparam int N_IRQ = 4;
  localparam int IRQ_LW = $clog2(N_IRQ);

  typedef enum logic {
    ROLE_AUX = 1'b0,
    ROLE_ARB = 1'b1
  } role_e;
endpackage

// File: rtl/rbg_init_gen.sv
module rbg_init_gen #(
  parameter int INIT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic dcok,
  input  logic wr,
  output logic binit
);
  localparam int CW = $clog2(INIT_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = (en && wr) || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (en && wr)           cnt_d = CW'(INIT_CYC);
    else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign binit = en && (!dcok || (cnt_q != '0));
endmodule

// File: rtl/rbg_arbiter.sv
module rbg_arbiter #(
  parameter int N_EXT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic             loc_req,
  input  logic [N_EXT-1:0] ext_req,
  input  logic             sack_in,
  output logic [N_EXT:0]   gnt
);
  localparam int NR = N_EXT + 1;

  logic [NR-1:0] req, pick, rel_vec, gnt_q, gnt_d;
  logic          held, release_now;

  assign req     = {ext_req, loc_req};
  assign pick    = req & (~req + NR'(1));
  assign rel_vec = {{N_EXT{sack_in}}, ~loc_req};
  assign held        = |gnt_q;
  assign release_now = |(gnt_q & rel_vec);

  always_comb begin
    gnt_d = '0;
    if (en && !clr) begin
      if (held)          gnt_d = release_now ? '0 : gnt_q;
      else if (!sack_in) gnt_d = pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt_q <= '0;
    else        gnt_q <= gnt_d;
  end

  assign gnt = gnt_q;
endmodule

// File: rtl/rbg_aux_port.sv
module rbg_aux_port (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  logic loc_req,
  input  logic grant_in,
  output logic taken,
  output logic grant_out
);
  logic taken_q, taken_d;

  always_comb begin
    taken_d = 1'b0;
    if (en && !clr) taken_d = taken_q ? loc_req : (grant_in && loc_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taken_q <= 1'b0;
    else        taken_q <= taken_d;
  end

  assign taken     = taken_q;
  assign grant_out = en && grant_in && !loc_req;
endmodule

// File: rtl/rbg_irq_front.sv
module rbg_irq_front
  import rbg_pkg::*;
(
  input  logic              en,
  input  logic [N_IRQ-1:0]  irq,
  input  logic              cpu_iack,
  input  logic              iack_in,
  output logic              pend,
  output logic [IRQ_LW-1:0] lvl,
  output logic              iack_out
);
  always_comb begin
    lvl = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (en && irq[i]) lvl = IRQ_LW'(i);
    end
  end

  assign pend     = en && (|irq);
  assign iack_out = en ? (cpu_iack && pend) : iack_in;
endmodule

// File: rtl/role_bus_glue.sv
module role_bus_glue
  import rbg_pkg::*;
#(
  parameter int N_EXT    = 3,
  parameter int INIT_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              role_arb_i,
  input  logic              loc_req_i,
  input  logic              dcok_i,
  input  logic              binit_wr_i,
  input  logic              grant_in_i,
  input  logic              sack_in_i,
  input  logic              binit_in_i,
  input  logic [N_EXT-1:0]  ext_req_i,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic              cpu_iack_i,
  input  logic              iack_in_i,
  output logic              bus_req_o,
  output logic              loc_grant_o,
  output logic [N_EXT-1:0]  ext_grant_o,
  output logic              sack_o,
  output logic              binit_o,
  output logic              grant_out_o,
  output logic              loc_rst_o,
  output logic              irq_pend_o,
  output logic [IRQ_LW-1:0] irq_lvl_o,
  output logic              iack_out_o
);
  role_e       role;
  logic        is_arb, is_aux, clr;
  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  logic [N_EXT:0] arb_gnt;
  logic        aux_taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign role   = role_e'(role_arb_i);
  assign is_arb = (role == ROLE_ARB);
  assign is_aux = (role == ROLE_AUX);
  assign clr    = !dcok_i || (is_aux && binit_in_i);

  rbg_arbiter #(.N_EXT(N_EXT)) u_arb (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en      (is_arb),
    .clr     (clr),
    .loc_req (loc_req_i),
    .ext_req (ext_req_i),
    .sack_in (sack_in_i),
    .gnt     (arb_gnt)
  );

  rbg_aux_port u_aux (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en        (is_aux),
    .clr       (clr),
    .loc_req   (loc_req_i),
    .grant_in  (grant_in_i),
    .taken     (aux_taken),
    .grant_out (grant_out_o)
  );

  rbg_init_gen #(.INIT_CYC(INIT_CYC)) u_init (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (is_arb),
    .dcok  (dcok_i),
    .wr    (binit_wr_i),
    .binit (binit_o)
  );

  rbg_irq_front u_irq (
    .en       (is_arb),
    .irq      (irq_i),
    .cpu_iack (cpu_iack_i),
    .iack_in  (iack_in_i),
    .pend     (irq_pend_o),
    .lvl      (irq_lvl_o),
    .iack_out (iack_out_o)
  );

  assign loc_grant_o = is_arb ? arb_gnt[0] : aux_taken;
  assign ext_grant_o = arb_gnt[N_EXT:1];
  assign sack_o      = is_aux && aux_taken;
  assign bus_req_o   = loc_req_i && !loc_grant_o;
  assign loc_rst_o   = clr;
endmodule

// File: rtl/rbg_glue_chk.sv
module rbg_glue_chk #(
  parameter int N_EXT = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             role_arb_i,
  input logic             loc_req_i,
  input logic             dcok_i,
  input logic             grant_in_i,
  input logic             sack_in_i,
  input logic             binit_in_i,
  input logic             loc_grant_o,
  input logic [N_EXT-1:0] ext_grant_o,
  input logic             sack_o,
  input logic             binit_o,
  input logic             grant_out_o,
  input logic             irq_pend_o
);
  // R2
  onehot_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ext_grant_o, loc_grant_o}));

  // R2
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (role_arb_i && !loc_grant_o && ext_grant_o == '0 && sack_in_i)
    |=> (!loc_grant_o && ext_grant_o == '0));

  // R3
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (role_arb_i && dcok_i && ext_grant_o != '0 && !sack_in_i)
    |=> (ext_grant_o == $past(ext_grant_o)));

  // R3
  ext_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (role_arb_i && ext_grant_o != '0 && sack_in_i) |=> (ext_grant_o == '0));

  // R4
  aux_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!role_arb_i && dcok_i && !binit_in_i && grant_in_i && loc_req_i) |=> sack_o);

  // R5
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_out_o |-> (grant_in_i && !loc_req_i && !role_arb_i));

  // R6
  no_sack_arb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    role_arb_i |-> !sack_o);

  // R7
  aux_no_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !role_arb_i |-> !binit_o);

  // R8
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dcok_i |=> (!loc_grant_o && ext_grant_o == '0 && !sack_o));

  // R9
  aux_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !role_arb_i |-> !irq_pend_o);
endmodule

bind role_bus_glue rbg_glue_chk #(.N_EXT(N_EXT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .role_arb_i  (role_arb_i),
  .loc_req_i   (loc_req_i),
  .dcok_i      (dcok_i),
  .grant_in_i  (grant_in_i),
  .sack_in_i   (sack_in_i),
  .binit_in_i  (binit_in_i),
  .loc_grant_o (loc_grant_o),
  .ext_grant_o (ext_grant_o),
  .sack_o      (sack_o),
  .binit_o     (binit_o),
  .grant_out_o (grant_out_o),
  .irq_pend_o  (irq_pend_o)
);

// File: tb/role_bus_glue_tb.sv
module role_bus_glue_tb;
  localparam int N_EXT = 3;
  localparam int INIT_CYC = 4;

  logic clk = 1'b0;
  logic rst_n, role_arb, loc_req, dcok, binit_wr, grant_in, sack_in, binit_in;
  logic [N_EXT-1:0] ext_req;
  logic [3:0] irq;
  logic cpu_iack, iack_in;
  logic bus_req, loc_grant, sack, binit, grant_out, loc_rst, irq_pend, iack_out;
  logic [N_EXT-1:0] ext_grant;
  logic [1:0] irq_lvl;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  role_bus_glue #(.N_EXT(N_EXT), .INIT_CYC(INIT_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .role_arb_i(role_arb), .loc_req_i(loc_req),
    .dcok_i(dcok), .binit_wr_i(binit_wr), .grant_in_i(grant_in),
    .sack_in_i(sack_in), .binit_in_i(binit_in), .ext_req_i(ext_req),
    .irq_i(irq), .cpu_iack_i(cpu_iack), .iack_in_i(iack_in),
    .bus_req_o(bus_req), .loc_grant_o(loc_grant), .ext_grant_o(ext_grant),
    .sack_o(sack), .binit_o(binit), .grant_out_o(grant_out),
    .loc_rst_o(loc_rst), .irq_pend_o(irq_pend), .irq_lvl_o(irq_lvl),
    .iack_out_o(iack_out)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int gvec();
    return int'({ext_grant, loc_grant});
  endfunction

  task automatic do_reset(input logic role);
    rst_n = 1'b0; role_arb = role;
    loc_req = 0; dcok = 1; binit_wr = 0; grant_in = 0; sack_in = 0;
    binit_in = 0; ext_req = '0; irq = '0; cpu_iack = 0; iack_in = 0;
    tick(); tick();
    rst_n = 1'b1;
    tick(); tick(); tick();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // ---------- arbiter role ----------
    do_reset(1'b1);
    chk("R2 reset grants", gvec(), 0);
    chk("R7 reset binit", int'(binit), 0);
    chk("R6 reset sack", int'(sack), 0);
    chk("R8 reset loc_rst", int'(loc_rst), 0);

    for (int p = 1; p < 16; p++) begin
      int w;
      w = p & (-p);
      loc_req = p[0]; ext_req = p[3:1]; sack_in = 1;
      tick();
      chk("R2 no grant while sack", gvec(), 0);
      chk("R1 bus_req ungranted", int'(bus_req), p & 1);
      sack_in = 0;
      tick();
      chk("R2 winner", gvec(), w);
      chk("R1 bus_req granted", int'(bus_req), (p & 1) & ((w & 1) ^ 1));
      chk("R6 sack arbiter", int'(sack), 0);
      tick(); tick();
      chk("R3 hold", gvec(), w);
      if (w == 1) loc_req = 0; else sack_in = 1;
      tick();
      chk("R3 release", gvec(), 0);
      loc_req = 0; ext_req = '0; sack_in = 0;
      tick();
    end

    // R8 dcok clears a held grant; R7 binit while dcok low
    ext_req = 3'b010;
    tick();
    chk("R2 ext grant", gvec(), 4);
    binit_in = 1;
    #1;
    chk("R8 binit_in ignored arb", int'(loc_rst), 0);
    tick();
    chk("R8 grant kept arb", gvec(), 4);
    binit_in = 0;
    dcok = 0;
    #1;
    chk("R8 loc_rst dcok", int'(loc_rst), 1);
    chk("R7 binit dcok", int'(binit), 1);
    tick();
    chk("R8 grant cleared", gvec(), 0);
    dcok = 1; ext_req = '0;
    tick();
    chk("R7 binit after dcok", int'(binit), 0);

    // R7 write strobe stretch
    binit_wr = 1;
    tick();
    binit_wr = 0;
    for (int k = 0; k < INIT_CYC; k++) begin
      chk("R7 binit stretch", int'(binit), 1);
      tick();
    end
    chk("R7 binit end", int'(binit), 0);

    // R9 / R10 arbiter sweep
    for (int v = 0; v < 16; v++) begin
      for (int c = 0; c < 2; c++) begin
        int hi;
        hi = 0;
        for (int b = 0; b < 4; b++) if (v[b]) hi = b;
        irq = v[3:0]; cpu_iack = c[0]; iack_in = 1;
        #1;
        chk("R9 pend arb", int'(irq_pend), int'(v != 0));
        chk("R9 lvl arb", int'(irq_lvl), hi);
        chk("R10 iack arb", int'(iack_out), c & int'(v != 0));
      end
    end
    irq = '0; cpu_iack = 0; iack_in = 0;
    #1;
    chk("R5 no pass in arb", int'(grant_out), 0);

    // ---------- auxiliary role ----------
    do_reset(1'b0);
    for (int g = 0; g < 2; g++) begin
      for (int lr = 0; lr < 2; lr++) begin
        grant_in = g[0]; loc_req = lr[0]; ext_req = 3'b111;
        #1;
        chk("R5 pass", int'(grant_out), g & (lr ^ 1));
        chk("R1 bus_req aux", int'(bus_req), lr);
        tick();
        chk("R4 take", int'(loc_grant), g & lr);
        chk("R4 sack", int'(sack), g & lr);
        chk("R4 no ext grant aux", int'(ext_grant), 0);
        grant_in = 0;
        tick();
        chk("R4 hold", int'(sack), g & lr);
        chk("R1 bus_req held", int'(bus_req), lr & ((g & lr) ^ 1));
        loc_req = 0;
        tick();
        chk("R4 drop", int'(sack), 0);
        ext_req = '0;
      end
    end

    // R7 aux never drives init
    dcok = 0;
    #1;
    chk("R7 aux dcok", int'(binit), 0);
    chk("R8 aux loc_rst dcok", int'(loc_rst), 1);
    dcok = 1;
    binit_wr = 1;
    tick();
    binit_wr = 0;
    for (int k = 0; k < INIT_CYC; k++) begin
      chk("R7 aux no stretch", int'(binit), 0);
      tick();
    end

    // R8 received init resets while holding
    grant_in = 1; loc_req = 1;
    tick();
    grant_in = 0;
    chk("R4 taken before init", int'(sack), 1);
    binit_in = 1;
    #1;
    chk("R8 loc_rst aux init", int'(loc_rst), 1);
    tick();
    chk("R8 cleared by init", int'(sack), 0);
    chk("R8 grant cleared by init", int'(loc_grant), 0);
    binit_in = 0; loc_req = 0;
    tick();

    // R9 / R10 auxiliary sweep
    for (int v = 0; v < 16; v++) begin
      for (int a = 0; a < 2; a++) begin
        irq = v[3:0]; iack_in = a[0]; cpu_iack = 1;
        #1;
        chk("R9 pend aux", int'(irq_pend), 0);
        chk("R9 lvl aux", int'(irq_lvl), 0);
        chk("R10 iack aux", int'(iack_out), a);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule